// File: doc/BRIEF.md
# Rotating Tiled Framebuffer Address Generator

This block turns a raster-ordered stream of output pixels into the byte address where each pixel is to be stored. Software programs the frame size (as size minus one), a quarter-turn rotation, a tile-layout enable and a pixel size, then pulses start. From then on every pixel strobe produces one address one clock later, and the address of the final pixel comes with a one-cycle frame-done pulse that can feed an interrupt-pending bit.

The incoming raster is `widthM1+1` columns by `heightM1+1` rows, x running fastest. Rotation remaps each raster coordinate into the stored surface. For quarter turns the stored surface is as wide as the raster is tall. The stored surface is either a plain row-major array or a sequence of 8x8 tiles, each tile row-major inside and the tiles themselves row-major. The configuration is captured at start, so the inputs may change freely while a frame runs.

Top module: `rot_tile_addr_gen`

## Requirements
- R1: After reset `addrValid` and `frameDone` are low and no frame is active.
- R2: With rotation 0 and tiling off, pixel (x, y) goes to `(y*W + x)*B`, where W is the raster width and B the bytes per pixel.
- R3: `pixMode` sets B: code 0 gives 4 bytes, code 1 gives 3 bytes, codes 2 and 3 give 2 bytes.
- R4: Rotation code 1 (quarter turn clockwise) stores raster pixel (x, y) at stored column H-1-y, stored row x, in a surface H wide (H is the raster height).
- R5: Rotation code 2 (half turn) stores pixel (x, y) at stored column W-1-x, stored row H-1-y, in a surface W wide.
- R6: Rotation code 3 (three quarter turns clockwise) stores pixel (x, y) at stored column y, stored row W-1-x, in a surface H wide.
- R7: With tiling on, stored point (sx, sy) in a surface SW wide goes to `(((sy/8)*(SW/8) + sx/8)*64 + (sy%8)*8 + sx%8)*B`.
- R8: A start with tiling on and a width or height not a multiple of 8 is rejected: pixel strobes that follow produce no address and no frame-done.
- R9: `frameDone` is high for exactly one cycle, together with the address of the last pixel; pixel strobes after it produce nothing until the next start.
- R10: A start pulse during an active frame is ignored; the frame continues from where it was.
- R11: Pixel strobes while no frame is active are ignored and do not move the pixel position of the next frame.
- R12: Size, rotation, tiling and pixel mode are captured at start; changing those inputs during a frame does not alter its addresses.
- R13: Each accepted pixel strobe yields `addrValid` with its address in the next cycle, whether strobes arrive back to back or with gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin a frame with the present configuration |
| widthM1 | input | 9 | Raster width minus one |
| heightM1 | input | 10 | Raster height minus one |
| rotCode | input | 2 | 0 none, 1 quarter turn CW, 2 half turn, 3 three quarter turns CW |
| tileEn | input | 1 | Store in 8x8 tile order |
| pixMode | input | 2 | Bytes per pixel code |
| pixValid | input | 1 | One output pixel arrives this cycle |
| addrValid | output | 1 | `addrOut` holds the address of the previous cycle's pixel |
| addrOut | output | 23 | Byte address of that pixel |
| frameDone | output | 1 | One-cycle pulse with the last pixel's address |

## Verification
Small frames that are not square are streamed through every rotation, so a swapped or mirrored axis gives a wrong address at once, and each of the four pixel mode codes is paired with a different rotation to separate the multipliers. Tiled frames spanning two tiles in one direction and two in the other show whether tile index, row inside the tile and tiles per row use the stored rather than the raster width. Frames with gaps between strobes against back-to-back bursts check the one-cycle latency, while strobes before start, after done and after a rejected start, plus a mid-frame start with changed inputs, show that position and configuration are held only by an accepted start.

// File: rtl/rtag_pkg.sv
package rtag_pkg;
  localparam int X_W = 9;
  localparam int Y_W = 10;

  typedef struct packed {
    logic load;
    logic step;
  } ctrlStrobes_t;
endpackage

// File: rtl/rtag_ctrl.sv
module rtag_ctrl
  import rtag_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startPulse,
  input  logic         pixValid,
  input  logic         tileEn,
  input  logic [2:0]   widthLow,
  input  logic [2:0]   heightLow,
  input  logic         lastPix,
  output ctrlStrobes_t strobes,
  output logic         frameDone
);
  logic active;
  logic badSize;

  assign badSize = tileEn && ((widthLow != 3'b111) || (heightLow != 3'b111));
  assign strobes.load = !active && startPulse && !badSize;
  assign strobes.step = active && pixValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= strobes.step && lastPix;
      if (strobes.load)
        active <= 1'b1;
      else if (strobes.step && lastPix)
        active <= 1'b0;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone); // R9
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (active && startPulse && !(pixValid && lastPix)) |=> active); // R10
  AST_REJECT_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!active && startPulse && badSize) |=> !active); // R8
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !active); // R9
endmodule

// File: rtl/rtag_datapath.sv
module rtag_datapath
  import rtag_pkg::*;
#(
  parameter int XW = X_W,
  parameter int YW = Y_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  strobes,
  input  logic [XW-1:0] widthM1,
  input  logic [YW-1:0] heightM1,
  input  logic [1:0]    rotCode,
  input  logic          tileEn,
  input  logic [1:0]    pixMode,
  output logic          lastPix,
  output logic          addrValid,
  output logic [2*YW+2:0] addrOut
);
  localparam int IDX_W  = 2 * YW + 1;
  localparam int ADDR_W = IDX_W + 2;

  logic [XW-1:0] wLat;
  logic [YW-1:0] hLat;
  logic [1:0]    rotLat;
  logic          tileLat;
  logic [1:0]    modeLat;
  logic [XW-1:0] xCnt;
  logic [YW-1:0] yCnt;

  logic [YW-1:0]    xExt, wExt, sx, sy, swM1;
  logic [IDX_W-1:0] sxW, syW, swW, tprW, linIdx, tileIdx, pixIdx;
  logic [ADDR_W-1:0] idxA, byteAddr, frameBytes;

  assign lastPix = (xCnt == wLat) && (yCnt == hLat);
  assign xExt = YW'(xCnt);
  assign wExt = YW'(wLat);

  always_comb begin
    unique case (rotLat)
      2'd0: begin sx = xExt;        sy = yCnt;        end
      2'd1: begin sx = hLat - yCnt; sy = xExt;        end
      2'd2: begin sx = wExt - xExt; sy = hLat - yCnt; end
      default: begin sx = yCnt;     sy = wExt - xExt; end
    endcase
    swM1 = rotLat[0] ? hLat : wExt;
  end

  assign sxW  = IDX_W'(sx);
  assign syW  = IDX_W'(sy);
  assign swW  = IDX_W'(swM1) + IDX_W'(1);
  assign tprW = swW >> 3;
  assign linIdx  = syW * swW + sxW;
  assign tileIdx = (((syW >> 3) * tprW + (sxW >> 3)) << 6)
                 + (IDX_W'(sy[2:0]) << 3) + IDX_W'(sx[2:0]);
  assign pixIdx  = tileLat ? tileIdx : linIdx;
  assign idxA    = ADDR_W'(pixIdx);

  always_comb begin
    unique case (modeLat)
      2'd0:    byteAddr = idxA << 2;
      2'd1:    byteAddr = (idxA << 1) + idxA;
      default: byteAddr = idxA << 1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wLat <= '0; hLat <= '0; rotLat <= '0; tileLat <= 1'b0; modeLat <= '0;
      xCnt <= '0; yCnt <= '0;
      addrValid <= 1'b0; addrOut <= '0;
    end else begin
      addrValid <= strobes.step;
      if (strobes.load) begin
        wLat <= widthM1; hLat <= heightM1; rotLat <= rotCode;
        tileLat <= tileEn; modeLat <= pixMode;
        xCnt <= '0; yCnt <= '0;
      end else if (strobes.step) begin
        addrOut <= byteAddr;
        if (xCnt == wLat) begin
          xCnt <= '0;
          yCnt <= yCnt + 1'b1;
        end else begin
          xCnt <= xCnt + 1'b1;
        end
      end
    end
  end

  assign frameBytes = (ADDR_W'(wLat) + ADDR_W'(1)) * (ADDR_W'(hLat) + ADDR_W'(1))
                    * ((modeLat == 2'd0) ? ADDR_W'(4) : (modeLat == 2'd1) ? ADDR_W'(3) : ADDR_W'(2));

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> (addrOut < frameBytes)); // R2
  AST_ADDR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> addrValid); // R13
endmodule

// File: rtl/rot_tile_addr_gen.sv
module rot_tile_addr_gen
  import rtag_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           startPulse,
  input  logic [X_W-1:0] widthM1,
  input  logic [Y_W-1:0] heightM1,
  input  logic [1:0]     rotCode,
  input  logic           tileEn,
  input  logic [1:0]     pixMode,
  input  logic           pixValid,
  output logic           addrValid,
  output logic [2*Y_W+2:0] addrOut,
  output logic           frameDone
);
  ctrlStrobes_t strobes;
  logic         lastPix;

  rtag_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .pixValid(pixValid),
    .tileEn(tileEn), .widthLow(widthM1[2:0]), .heightLow(heightM1[2:0]),
    .lastPix(lastPix), .strobes(strobes), .frameDone(frameDone)
  );

  rtag_datapath #(.XW(X_W), .YW(Y_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .widthM1(widthM1),
    .heightM1(heightM1), .rotCode(rotCode), .tileEn(tileEn), .pixMode(pixMode),
    .lastPix(lastPix), .addrValid(addrValid), .addrOut(addrOut)
  );

  AST_DONE_WITH_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> addrValid); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!addrValid && !frameDone)); // R1
endmodule

// File: tb/rot_tile_addr_gen_tb.sv
module rot_tile_addr_gen_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [8:0] widthM1 = '0;
  logic [9:0] heightM1 = '0;
  logic [1:0] rotCode = '0;
  logic tileEn = 1'b0;
  logic [1:0] pixMode = '0;
  logic pixValid = 1'b0;
  logic addrValid;
  logic [22:0] addrOut;
  logic frameDone;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rot_tile_addr_gen u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .widthM1(widthM1),
    .heightM1(heightM1), .rotCode(rotCode), .tileEn(tileEn), .pixMode(pixMode),
    .pixValid(pixValid), .addrValid(addrValid), .addrOut(addrOut), .frameDone(frameDone)
  );

  task automatic checkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expAddr(int x, int y, int w, int h, int rot, int tile, int mode);
    int sx, sy, sw, idx, bpp;
    case (rot)
      0: begin sx = x;         sy = y;         sw = w; end
      1: begin sx = h - 1 - y; sy = x;         sw = h; end
      2: begin sx = w - 1 - x; sy = h - 1 - y; sw = w; end
      default: begin sx = y;   sy = w - 1 - x; sw = h; end
    endcase
    if (tile != 0)
      idx = ((sy / 8) * (sw / 8) + sx / 8) * 64 + (sy % 8) * 8 + (sx % 8);
    else
      idx = sy * sw + sx;
    bpp = (mode == 0) ? 4 : (mode == 1) ? 3 : 2;
    return idx * bpp;
  endfunction

  task automatic startFrame(int w, int h, int rot, int tile, int mode);
    @(negedge clk);
    widthM1 = 9'(w - 1); heightM1 = 10'(h - 1);
    rotCode = 2'(rot); tileEn = 1'(tile); pixMode = 2'(mode);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic checkPix(string tag, int p, int w, int h, int rot, int tile, int mode);
    checkEq({tag, " addrValid"}, int'(addrValid), 1);
    checkEq({tag, " addr"}, int'(addrOut), expAddr(p % w, p / w, w, h, rot, tile, mode));
    checkEq({tag, " frameDone"}, int'(frameDone), (p == w * h - 1) ? 1 : 0);
  endtask

  task automatic streamPix(string tag, int w, int h, int rot, int tile, int mode,
                           int first, int count, bit burst);
    for (int k = 0; k < count; k++) begin
      @(negedge clk);
      if (burst && k > 0) checkPix(tag, first + k - 1, w, h, rot, tile, mode);
      pixValid = 1'b1;
      if (!burst) begin
        @(negedge clk);
        pixValid = 1'b0;
        checkPix(tag, first + k, w, h, rot, tile, mode);
      end
    end
    if (burst) begin
      @(negedge clk);
      pixValid = 1'b0;
      checkPix(tag, first + count - 1, w, h, rot, tile, mode);
    end
  endtask

  task automatic expectSilent(string tag, int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      pixValid = 1'b1;
      @(negedge clk);
      pixValid = 1'b0;
      checkEq({tag, " addrValid"}, int'(addrValid), 0);
      checkEq({tag, " frameDone"}, int'(frameDone), 0);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    checkEq("R1 addrValid", int'(addrValid), 0);
    checkEq("R1 frameDone", int'(frameDone), 0);
  endtask

  task automatic testIdleStrobes();
    expectSilent("R11 idle", 3);
    startFrame(4, 3, 0, 0, 0);
    streamPix("R11 R2 R3 R13 linear", 4, 3, 0, 0, 0, 0, 12, 1'b0);
  endtask

  task automatic testRotations();
    startFrame(5, 3, 1, 0, 1);
    streamPix("R4 R3 rot90", 5, 3, 1, 0, 1, 0, 15, 1'b1);
    startFrame(5, 3, 2, 0, 2);
    streamPix("R5 R3 rot180", 5, 3, 2, 0, 2, 0, 15, 1'b0);
    startFrame(3, 5, 3, 0, 3);
    streamPix("R6 R3 rot270", 3, 5, 3, 0, 3, 0, 15, 1'b1);
  endtask

  task automatic testAfterDone();
    expectSilent("R9 after done", 3);
  endtask

  task automatic testTiled();
    startFrame(16, 8, 0, 1, 1);
    streamPix("R7 tiled rot0", 16, 8, 0, 1, 1, 0, 128, 1'b1);
    startFrame(8, 16, 1, 1, 0);
    streamPix("R7 tiled rot90", 8, 16, 1, 1, 0, 0, 128, 1'b1);
    startFrame(16, 16, 3, 1, 2);
    streamPix("R7 tiled rot270", 16, 16, 3, 1, 2, 0, 256, 1'b1);
  endtask

  task automatic testReject();
    startFrame(12, 8, 0, 1, 0);
    expectSilent("R8 bad width", 3);
    startFrame(8, 12, 0, 1, 0);
    expectSilent("R8 bad height", 3);
    startFrame(8, 8, 2, 1, 0);
    streamPix("R8 R7 good after reject", 8, 8, 2, 1, 0, 0, 64, 1'b1);
  endtask

  task automatic testMidFrame();
    startFrame(4, 2, 0, 0, 0);
    streamPix("R10 R12 head", 4, 2, 0, 0, 0, 0, 3, 1'b1);
    @(negedge clk);
    widthM1 = 9'd7; heightM1 = 10'd7; rotCode = 2'd2; pixMode = 2'd2; tileEn = 1'b1;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    checkEq("R10 no addr from start", int'(addrValid), 0);
    streamPix("R10 R12 tail", 4, 2, 0, 0, 0, 3, 5, 1'b0);
    expectSilent("R9 R10 frame ended", 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testIdleStrobes();
    testRotations();
    testAfterDone();
    testTiled();
    testReject();
    testMidFrame();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule